// File: doc/BRIEF.md
# Tagged Reservation Station Pool

This block holds operations that are waiting to run on two pools of execution units: an adder unit and a multiplier unit. Operations arrive in program order on a single issue port. Each one names a unit class, an operation code, a destination register and two source registers. The block keeps one status entry per architectural register: a value, a busy flag and a producer tag. At issue, each source becomes either a plain value or the tag of the station that will produce it. The destination's status entry is then claimed by the newly allocated station.

Stations that are missing an operand watch a single shared result bus and pick the value up when the tag on the bus matches the one they recorded. A station whose operands are all present is sent to its unit; among several ready stations, the one allocated earliest goes first. The units are fixed-latency stand-ins. Their results return on the shared bus, one per cycle. The bus updates the register entries that are still waiting on that tag and frees the producing station.

Station tags are small integers. Adder stations carry tags 1 to N_ADD, multiplier stations carry tags N_ADD+1 to N_ADD+N_MUL, and tag 0 means "no producer".

Top module: `tsp_station_pool`

## Requirements
- R1: `iss_ready` is high exactly when the class selected by `iss_unit` (0 adder, 1 multiplier) has a free station. An operation presented while `iss_ready` is low is not accepted and changes no register status.
- R2: At issue, a source whose register is not busy is captured as that register's value. A busy source records the register's producer tag instead.
- R3: In the cycle after an operation is accepted, its destination register reads busy, and its tag equals the allocated station's tag. The lowest-numbered free station of the class is the one allocated.
- R4: A station waiting on a tag takes `bus_data` in the cycle that `bus_valid` is high with that `bus_tag`.
- R5: A station is sent to its unit only once both of its operands hold values, and each station is sent exactly once.
- R6: A broadcast sets every register whose tag equals `bus_tag` to `bus_data` and clears its busy flag.
- R7: At most one result is broadcast per cycle. When both units finish in the same cycle, the adder result goes first and the multiplier result follows in the next cycle.
- R8: An independent operation accepted at clock edge k is on the bus (for one cycle) from edge k+LAT+1, where LAT is LAT_ADD or LAT_MUL. It is not on the bus before that edge.
- R9: A broadcast whose tag no longer matches a register's tag leaves that register untouched. An older result never replaces a newer writer.
- R10: When several stations of one class are ready, the one allocated earliest is dispatched first, whatever its index.
- R11: A source whose producer broadcasts in the same cycle that its consumer is accepted is taken straight from the bus.
- R12: The adder unit returns a+b for op 0 and a-b for op 1. The multiplier returns the low DW bits of a*b.
- R13: After reset every register i holds i+1 and is not busy, the bus is idle and both classes have room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered on the issue port |
| iss_unit | input | 1 | Unit class: 0 adder, 1 multiplier |
| iss_op | input | 1 | Adder operation: 0 add, 1 subtract (ignored by the multiplier) |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_srca | input | $clog2(NREG) | First source register |
| iss_srcb | input | $clog2(NREG) | Second source register |
| iss_ready | output | 1 | The selected class has a free station |
| bus_valid | output | 1 | A result is broadcast this cycle |
| bus_tag | output | $clog2(N_ADD+N_MUL+1) | Tag of the broadcasting station |
| bus_data | output | DW | Broadcast result |
| rd_addr | input | $clog2(NREG) | Register status inspection address |
| rd_data | output | DW | Value of the inspected register |
| rd_busy | output | 1 | Busy flag of the inspected register |
| rd_tag | output | $clog2(N_ADD+N_MUL+1) | Producer tag of the inspected register |

## Verification
The bench targets the cycle in which a producer's result is on the bus at the same time as a consumer of that result is accepted at the issue port. It waits until the producer's broadcast is visible. It then offers the dependent operation in that same cycle, so the register status still reads busy while the bus already carries the value. The outcome is judged by whether the consumer completes with the correct value; without the direct capture, it would wait forever on a tag that has already gone by. A second collision, both units finishing together, is provoked by spacing a multiplication and an addition so that their latencies end in the same cycle. The bench then checks the order of the tags on the bus.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic {UNIT_ADD = 1'b0, UNIT_MUL = 1'b1} unit_e;
  typedef enum logic {OP_SUM = 1'b0, OP_DIFF = 1'b1} addop_e;
endpackage

// File: rtl/tsp_reg_status.sv
module tsp_reg_status #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  parameter int RW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wdst,
  input  logic [TW-1:0] wtag,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  output logic [DW-1:0] ra_val,
  output logic          ra_busy,
  output logic [TW-1:0] ra_tag,
  output logic [DW-1:0] rb_val,
  output logic          rb_busy,
  output logic [TW-1:0] rb_tag,
  input  logic [RW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_val,
  output logic          dbg_busy,
  output logic [TW-1:0] dbg_tag,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data
);
  logic [DW-1:0] val_q  [NREG];
  logic          busy_q [NREG];
  logic [TW-1:0] tag_q  [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        val_q[r]  <= DW'(r + 1);
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        // only the writer named by the current tag may retire the entry
        if (bus_valid && busy_q[r] && tag_q[r] == bus_tag) begin
          val_q[r]  <= bus_data;
          busy_q[r] <= 1'b0;
        end
        // a new claim at issue overrides a retirement in the same cycle
        if (we && wdst == RW'(r)) begin
          busy_q[r] <= 1'b1;
          tag_q[r]  <= wtag;
        end
      end
    end
  end

  assign ra_val   = val_q[ra];
  assign ra_busy  = busy_q[ra];
  assign ra_tag   = tag_q[ra];
  assign rb_val   = val_q[rb];
  assign rb_busy  = busy_q[rb];
  assign rb_tag   = tag_q[rb];
  assign dbg_val  = val_q[dbg_addr];
  assign dbg_busy = busy_q[dbg_addr];
  assign dbg_tag  = tag_q[dbg_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_claim_r3: assert property (@(posedge clk) disable iff (rst)
      (we && wdst == RW'(g)) |=> (busy_q[g] && tag_q[g] == $past(wtag)));
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && busy_q[g] && tag_q[g] == bus_tag && !(we && wdst == RW'(g)))
        |=> (!busy_q[g] && val_q[g] == $past(bus_data)));
    p_newer_kept_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && busy_q[g] && tag_q[g] != bus_tag) |=> (busy_q[g] && $stable(val_q[g])));
  end
endmodule

// File: rtl/tsp_station_bank.sv
module tsp_station_bank #(
  parameter int N        = 3,
  parameter int DW       = 16,
  parameter int TW       = 3,
  parameter int TAG_BASE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          a_op,
  input  logic          a_ok,
  input  logic [DW-1:0] a_val,
  input  logic [TW-1:0] a_tag,
  input  logic          b_ok,
  input  logic [DW-1:0] b_val,
  input  logic [TW-1:0] b_tag,
  output logic          room,
  output logic [TW-1:0] new_tag,
  input  logic          fu_idle,
  output logic          fire,
  output logic          f_op,
  output logic [DW-1:0] f_a,
  output logic [DW-1:0] f_b,
  output logic [TW-1:0] f_tag,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          busy_q  [N];
  logic          fired_q [N];
  logic          op_q    [N];
  logic          ok1_q   [N];
  logic          ok2_q   [N];
  logic [DW-1:0] v1_q    [N];
  logic [DW-1:0] v2_q    [N];
  logic [TW-1:0] q1_q    [N];
  logic [TW-1:0] q2_q    [N];
  // older_q[j][i] set: station j was allocated before station i
  logic [N-1:0]  older_q [N];

  logic [N-1:0]  ready;
  logic [N-1:0]  blocked;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] sel_idx;
  logic          any_ready;

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assign ready[i] = busy_q[i] && !fired_q[i] && ok1_q[i] && ok2_q[i];
  end

  always_comb begin
    free_idx = '0;
    room     = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_idx = IW'(i);
        room     = 1'b1;
      end
    end
  end
  assign new_tag = TW'(TAG_BASE) + TW'(free_idx);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ready[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_idx   = '0;
    any_ready = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && !blocked[i]) begin
        sel_idx   = IW'(i);
        any_ready = 1'b1;
      end
    end
  end

  assign fire  = any_ready && fu_idle;
  assign f_op  = op_q[sel_idx];
  assign f_a   = v1_q[sel_idx];
  assign f_b   = v2_q[sel_idx];
  assign f_tag = TW'(TAG_BASE) + TW'(sel_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        busy_q[i]  <= 1'b0;
        fired_q[i] <= 1'b0;
        op_q[i]    <= 1'b0;
        ok1_q[i]   <= 1'b0;
        ok2_q[i]   <= 1'b0;
        v1_q[i]    <= '0;
        v2_q[i]    <= '0;
        q1_q[i]    <= '0;
        q2_q[i]    <= '0;
        older_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (bus_valid && busy_q[i]) begin
          if (!ok1_q[i] && bus_tag == q1_q[i]) begin
            v1_q[i]  <= bus_data;
            ok1_q[i] <= 1'b1;
          end
          if (!ok2_q[i] && bus_tag == q2_q[i]) begin
            v2_q[i]  <= bus_data;
            ok2_q[i] <= 1'b1;
          end
          if (bus_tag == TW'(TAG_BASE + i)) busy_q[i] <= 1'b0;
        end
      end
      if (fire) fired_q[sel_idx] <= 1'b1;
      if (alloc) begin
        busy_q[free_idx]  <= 1'b1;
        fired_q[free_idx] <= 1'b0;
        op_q[free_idx]    <= a_op;
        ok1_q[free_idx]   <= a_ok;
        ok2_q[free_idx]   <= b_ok;
        v1_q[free_idx]    <= a_val;
        v2_q[free_idx]    <= b_val;
        q1_q[free_idx]    <= a_tag;
        q2_q[free_idx]    <= b_tag;
        for (int k = 0; k < N; k++) older_q[k][free_idx] <= 1'b1;
        older_q[free_idx] <= '0;
      end
    end
  end

  p_alloc_room_r1: assert property (@(posedge clk) disable iff (rst) alloc |-> room);

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_wait_operands_r5: assert property (@(posedge clk) disable iff (rst)
      (!ok1_q[g] || !ok2_q[g]) |-> !(fire && sel_idx == IW'(g)));
    p_once_r5: assert property (@(posedge clk) disable iff (rst)
      (fired_q[g] && busy_q[g]) |-> !(fire && sel_idx == IW'(g)));
    p_freed_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && busy_q[g] && bus_tag == TW'(TAG_BASE + g)) |=> !busy_q[g]);
  end
endmodule

// File: rtl/tsp_fu_stub.sv
module tsp_fu_stub #(
  parameter int DW     = 16,
  parameter int TW     = 3,
  parameter int LAT    = 2,
  parameter bit IS_MUL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [TW-1:0] tag_in,
  input  logic          grant,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [TW-1:0] tag_out
);
  import tsp_pkg::*;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] calc;

  if (IS_MUL) begin : g_mul
    logic unused_op;
    assign unused_op = op;
    assign calc      = a * b;
  end else begin : g_add
    assign calc = (addop_e'(op) == OP_DIFF) ? (a - b) : (a + b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      res     <= '0;
      tag_out <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= CW'(LAT - 1);
      res     <= calc;
      tag_out <= tag_in;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (grant) begin
      busy_q <= 1'b0;
    end
  end

  assign idle = !busy_q;
  assign done = busy_q && cnt_q == '0;

  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst) start |-> idle);
  p_min_latency_r8: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy_q));
  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !grant) |=> (done && $stable(res) && $stable(tag_out)));
endmodule

// File: rtl/tsp_station_pool.sv
module tsp_station_pool
  import tsp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NREG    = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 4,
  localparam int RW     = $clog2(NREG),
  localparam int TW     = $clog2(N_ADD + N_MUL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic          iss_unit,
  input  logic          iss_op,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_srca,
  input  logic [RW-1:0] iss_srcb,
  output logic          iss_ready,
  output logic          bus_valid,
  output logic [TW-1:0] bus_tag,
  output logic [DW-1:0] bus_data,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_busy,
  output logic [TW-1:0] rd_tag
);
  localparam int ADD_BASE = 1;
  localparam int MUL_BASE = 1 + N_ADD;

  unit_e         unit_s;
  logic          accept, add_alloc, mul_alloc;
  logic          add_room, mul_room;
  logic [TW-1:0] add_ntag, mul_ntag, new_tag;

  logic [DW-1:0] sa_val, sb_val, a_val, b_val;
  logic          sa_busy, sb_busy, a_ok, b_ok;
  logic [TW-1:0] sa_tag, sb_tag;

  logic          add_fire, mul_fire, add_fop, mul_fop;
  logic [DW-1:0] add_fa, add_fb, mul_fa, mul_fb;
  logic [TW-1:0] add_ftag, mul_ftag;
  logic          add_idle, mul_idle, add_done, mul_done;
  logic [DW-1:0] add_res, mul_res;
  logic [TW-1:0] add_rtag, mul_rtag;
  logic          gnt_add, gnt_mul;

  assign unit_s    = unit_e'(iss_unit);
  assign iss_ready = (unit_s == UNIT_MUL) ? mul_room : add_room;
  assign accept    = iss_valid && iss_ready;
  assign add_alloc = accept && unit_s == UNIT_ADD;
  assign mul_alloc = accept && unit_s == UNIT_MUL;
  assign new_tag   = (unit_s == UNIT_MUL) ? mul_ntag : add_ntag;

  // source resolution: register value, same-cycle broadcast, or producer tag
  always_comb begin
    a_ok  = !sa_busy || (bus_valid && bus_tag == sa_tag);
    a_val = sa_busy ? bus_data : sa_val;
    b_ok  = !sb_busy || (bus_valid && bus_tag == sb_tag);
    b_val = sb_busy ? bus_data : sb_val;
  end

  tsp_reg_status #(.NREG(NREG), .DW(DW), .TW(TW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst),
    .we(accept), .wdst(iss_dst), .wtag(new_tag),
    .ra(iss_srca), .rb(iss_srcb),
    .ra_val(sa_val), .ra_busy(sa_busy), .ra_tag(sa_tag),
    .rb_val(sb_val), .rb_busy(sb_busy), .rb_tag(sb_tag),
    .dbg_addr(rd_addr), .dbg_val(rd_data), .dbg_busy(rd_busy), .dbg_tag(rd_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  tsp_station_bank #(.N(N_ADD), .DW(DW), .TW(TW), .TAG_BASE(ADD_BASE)) u_add_bank (
    .clk(clk), .rst(rst), .alloc(add_alloc), .a_op(iss_op),
    .a_ok(a_ok), .a_val(a_val), .a_tag(sa_tag),
    .b_ok(b_ok), .b_val(b_val), .b_tag(sb_tag),
    .room(add_room), .new_tag(add_ntag), .fu_idle(add_idle),
    .fire(add_fire), .f_op(add_fop), .f_a(add_fa), .f_b(add_fb), .f_tag(add_ftag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  tsp_station_bank #(.N(N_MUL), .DW(DW), .TW(TW), .TAG_BASE(MUL_BASE)) u_mul_bank (
    .clk(clk), .rst(rst), .alloc(mul_alloc), .a_op(iss_op),
    .a_ok(a_ok), .a_val(a_val), .a_tag(sa_tag),
    .b_ok(b_ok), .b_val(b_val), .b_tag(sb_tag),
    .room(mul_room), .new_tag(mul_ntag), .fu_idle(mul_idle),
    .fire(mul_fire), .f_op(mul_fop), .f_a(mul_fa), .f_b(mul_fb), .f_tag(mul_ftag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  tsp_fu_stub #(.DW(DW), .TW(TW), .LAT(LAT_ADD), .IS_MUL(1'b0)) u_add_fu (
    .clk(clk), .rst(rst), .start(add_fire), .op(add_fop), .a(add_fa), .b(add_fb),
    .tag_in(add_ftag), .grant(gnt_add), .idle(add_idle), .done(add_done),
    .res(add_res), .tag_out(add_rtag)
  );

  tsp_fu_stub #(.DW(DW), .TW(TW), .LAT(LAT_MUL), .IS_MUL(1'b1)) u_mul_fu (
    .clk(clk), .rst(rst), .start(mul_fire), .op(mul_fop), .a(mul_fa), .b(mul_fb),
    .tag_in(mul_ftag), .grant(gnt_mul), .idle(mul_idle), .done(mul_done),
    .res(mul_res), .tag_out(mul_rtag)
  );

  // fixed priority for the single result bus: adder first
  assign gnt_add = add_done;
  assign gnt_mul = mul_done && !add_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_data  <= '0;
    end else begin
      bus_valid <= gnt_add || gnt_mul;
      if (gnt_add) begin
        bus_tag  <= add_rtag;
        bus_data <= add_res;
      end else if (gnt_mul) begin
        bus_tag  <= mul_rtag;
        bus_data <= mul_res;
      end else begin
        bus_tag <= '0;
      end
    end
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst) $onehot0({gnt_add, gnt_mul}));
  p_tie_mul_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (add_done && mul_done) |=> (mul_done && bus_valid && bus_tag == $past(add_rtag)));
  p_bus_tagged_r7: assert property (@(posedge clk) disable iff (rst) bus_valid |-> bus_tag != '0);
  p_no_alloc_stall_r1: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |-> !(add_alloc || mul_alloc));
endmodule

// File: tb/tsp_station_pool_bench.sv
`timescale 1ns/1ps
module tsp_station_pool_bench;
  localparam int DW = 16, NREG = 8, N_ADD = 3, N_MUL = 2, LAT_ADD = 2, LAT_MUL = 4;
  localparam int NV = 12;
  // vector: {unit, op, dst, srca, srcb}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 3'd1, 3'd2},
    {1'b1, 1'b0, 3'd3, 3'd0, 3'd4},
    {1'b0, 1'b1, 3'd4, 3'd3, 3'd1},
    {1'b0, 1'b0, 3'd0, 3'd5, 3'd6},
    {1'b1, 1'b0, 3'd6, 3'd6, 3'd7},
    {1'b0, 1'b1, 3'd7, 3'd0, 3'd4},
    {1'b0, 1'b0, 3'd1, 3'd3, 3'd3},
    {1'b1, 1'b0, 3'd2, 3'd1, 3'd0},
    {1'b0, 1'b0, 3'd5, 3'd2, 3'd7},
    {1'b0, 1'b1, 3'd3, 3'd5, 3'd6},
    {1'b1, 1'b0, 3'd4, 3'd4, 3'd4},
    {1'b0, 1'b0, 3'd6, 3'd1, 3'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0, iss_unit = 1'b0, iss_op = 1'b0;
  logic [2:0] iss_dst = '0, iss_srca = '0, iss_srcb = '0, rd_addr = '0;
  logic iss_ready, bus_valid, rd_busy;
  logic [2:0] bus_tag, rd_tag;
  logic [DW-1:0] bus_data, rd_data;

  int nchk = 0, nerr = 0, nlog = 0;
  bit finished = 0, log_on = 0;
  logic [DW-1:0] mdl [NREG];
  logic [2:0] blog [16];

  always #2.5 clk = ~clk;

  tsp_station_pool #(.DW(DW), .NREG(NREG), .N_ADD(N_ADD), .N_MUL(N_MUL),
                     .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)) u_tsp_station_pool (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb), .iss_ready(iss_ready),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_busy(rd_busy), .rd_tag(rd_tag));

  always @(negedge clk) begin
    if (log_on && bus_valid) begin
      if (nlog < 16) blog[nlog] = bus_tag;
      nlog++;
    end
  end

  function automatic logic [DW-1:0] calc(input logic u, input logic o, input logic [DW-1:0] a, b);
    if (u) return a * b;
    return o ? (a - b) : (a + b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input int r);
    rd_addr = 3'(r);
    #1;
  endtask

  // drives one operation, waits for room, returns at the negedge after acceptance
  task automatic issue(input logic u, input logic o, input int d, input int a, input int b);
    iss_unit = u; iss_op = o;
    iss_dst = 3'(d); iss_srca = 3'(a); iss_srcb = 3'(b);
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    iss_valid = 1'b1;
    @(posedge clk);
    mdl[d] = calc(u, o, mdl[a], mdl[b]);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic drain_and_compare(input string req);
    step(150);
    for (int r = 0; r < NREG; r++) begin
      peek(r);
      check(req, {15'd0, rd_busy, rd_data}, {16'd0, mdl[r]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) mdl[r] = DW'(r + 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1);

    // R13 reset state
    for (int r = 0; r < NREG; r++) begin
      peek(r);
      check("R13 reset value/busy", {15'd0, rd_busy, rd_data}, {16'd0, DW'(r + 1)});
    end
    check("R13 bus idle", {31'd0, bus_valid}, 32'd0);
    iss_unit = 1'b0; #1; check("R13 adder room", {31'd0, iss_ready}, 32'd1);
    iss_unit = 1'b1; #1; check("R13 multiplier room", {31'd0, iss_ready}, 32'd1);

    // R8/R3/R12: lone add, exact bus timing
    issue(1'b0, 1'b0, 0, 1, 2);
    peek(0);
    check("R3 dst busy after issue", {31'd0, rd_busy}, 32'd1);
    check("R3 dst tag = adder station 1", {29'd0, rd_tag}, 32'd1);
    step(LAT_ADD);
    check("R8 not on bus early", {31'd0, bus_valid}, 32'd0);
    step(1);
    check("R8 on bus at k+LAT+1", {31'd0, bus_valid}, 32'd1);
    check("R8 bus tag", {29'd0, bus_tag}, 32'd1);
    check("R12 sum", {16'd0, bus_data}, {16'd0, mdl[0]});
    step(1);
    peek(0);
    check("R6 register released", {15'd0, rd_busy, rd_data}, {16'd0, mdl[0]});

    // vector table walked in program order (R2 R4 R5 R6 R12)
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][10], VEC[v][9], int'(VEC[v][8:6]), int'(VEC[v][5:3]), int'(VEC[v][2:0]));
    end
    drain_and_compare("R2 R4 R5 R12 table result");

    // R7: both units finish in the same cycle
    issue(1'b1, 1'b0, 2, 3, 4);
    step(1);
    issue(1'b0, 1'b1, 5, 6, 7);
    step(3);
    check("R7 tie: adder first", {29'd0, bus_tag}, 32'd1);
    check("R7 tie: adder data", {16'd0, bus_data}, {16'd0, mdl[5]});
    step(1);
    check("R7 tie: multiplier next", {29'd0, bus_tag}, 32'd4);
    check("R7 tie: multiplier data", {16'd0, bus_data}, {16'd0, mdl[2]});
    drain_and_compare("R7 after tie");

    // R9: slow older writer, fast newer writer to the same register
    issue(1'b1, 1'b0, 1, 2, 3);
    issue(1'b0, 1'b0, 1, 4, 5);
    step(4);
    check("R9 stale result on bus", {29'd0, bus_tag}, 32'd4);
    step(2);
    peek(1);
    check("R9 newer writer kept", {15'd0, rd_busy, rd_data}, {16'd0, mdl[1]});
    drain_and_compare("R9 after stale broadcast");

    // R1: fill adder stations behind a pending multiply
    issue(1'b1, 1'b0, 1, 1, 1);
    peek(1);
    check("R3 multiplier tag", {29'd0, rd_tag}, 32'd4);
    issue(1'b0, 1'b0, 5, 1, 2);
    issue(1'b0, 1'b0, 6, 1, 3);
    issue(1'b0, 1'b1, 7, 1, 1);
    iss_unit = 1'b0; #1;
    check("R1 adder full -> stall", {31'd0, iss_ready}, 32'd0);
    iss_unit = 1'b1; #1;
    check("R1 multiplier still has room", {31'd0, iss_ready}, 32'd1);
    iss_unit = 1'b0; iss_op = 1'b0; iss_dst = 3'd0; iss_srca = 3'd2; iss_srcb = 3'd3;
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
    peek(0);
    check("R1 refused op leaves dst untouched", {15'd0, rd_busy, rd_data}, {16'd0, mdl[0]});
    drain_and_compare("R4 snooped operands");

    // R11: consumer accepted while producer broadcasts
    issue(1'b1, 1'b0, 1, 2, 2);
    while (!bus_valid) @(negedge clk);
    issue(1'b0, 1'b0, 4, 1, 1);
    step(150);
    peek(4);
    check("R11 same-cycle capture", {15'd0, rd_busy, rd_data}, {16'd0, mdl[4]});
    drain_and_compare("R11 after bypass");

    // R10: station 0 reused later must dispatch after older stations 1 and 2
    nlog = 0;
    log_on = 1'b1;
    issue(1'b1, 1'b0, 1, 2, 3);
    issue(1'b0, 1'b0, 0, 4, 5);
    issue(1'b0, 1'b0, 5, 1, 6);
    issue(1'b0, 1'b0, 6, 1, 7);
    issue(1'b0, 1'b1, 7, 1, 0);
    drain_and_compare("R10 values");
    log_on = 1'b0;
    check("R10 broadcast count", nlog, 5);
    check("R10 order 0", {29'd0, blog[0]}, 32'd1);
    check("R10 order 1", {29'd0, blog[1]}, 32'd4);
    check("R10 oldest first (station 2)", {29'd0, blog[2]}, 32'd2);
    check("R10 next oldest (station 3)", {29'd0, blog[3]}, 32'd3);
    check("R10 youngest last (station 1)", {29'd0, blog[4]}, 32'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule